// File: doc/BRIEF.md
# Byte Handshake Input Word Packer

This block sits between a slow external 8-bit parallel port and a hashing core. The port presents a byte together with a "buffer full" style strobe. The block synchronises that strobe, takes one byte per strobe phase and answers with an acknowledge that it holds until the strobe is withdrawn. Bytes go into a 64-entry byte buffer. After the 64th byte, the full 512-bit block is offered to the core as sixteen 32-bit words.

Each word is built from four consecutive buffered bytes, with the earliest byte in the most significant lane. Port loading is enabled only while the core's hash-done input is high. While a filled block still waits to be drained, loading is also held off. The core reads through a valid/ready stream. The block holds the current word and its index steady for as long as ready stays low, and it never drops valid until all sixteen words have been accepted.

Top module: `byte_word_packer`

## Requirements
- R1: After reset, `port_ack`, `word_valid`, `word_last` and `block_ready` are all low.
- R2: With loading enabled and the block idle, `port_ack` rises on the third rising clock edge after `port_valid` rises, and the byte on `port_data` is stored at that edge. `port_ack` falls on the third rising edge after `port_valid` falls.
- R3: Exactly one byte is stored per assertion of `port_valid`, however long the strobe is held high.
- R4: While `hash_done` is low, a strobe is neither acknowledged nor stored. Once `hash_done` goes high with the strobe still held, the transfer completes normally.
- R5: `block_ready` and `word_valid` rise together at the edge that stores the 64th byte of a block, and not earlier.
- R6: Word k (k = 0..15) of a block is {byte 4k, byte 4k+1, byte 4k+2, byte 4k+3}. Byte 4k is in bits 31:24, and the bytes are numbered in the order they arrived.
- R7: While `word_valid` is high and `word_ready` is low, `word_valid` stays high and `word_data` is stable. A word is accepted at a rising edge where both are high.
- R8: `word_last` is high exactly while word 15 is offered. `word_valid` drops at the edge that accepts word 15.
- R9: `block_ready` clears at the edge that accepts the first word of a block.
- R10: While a filled block is not yet fully drained, strobes are not acknowledged. Loading resumes once the last word has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hash_done | input | 1 | Core reports that the previous hash has finished; enables loading |
| port_data | input | 8 | Byte from the external port, stable while its strobe is high |
| port_valid | input | 1 | External strobe: a byte is waiting (asynchronous) |
| port_ack | output | 1 | Acknowledge to the external port; high from capture until the strobe is withdrawn |
| word_data | output | 32 | Current 32-bit word, earliest byte in bits 31:24 |
| word_valid | output | 1 | A word of a complete block is offered |
| word_ready | input | 1 | Core accepts the offered word |
| word_last | output | 1 | The offered word is the sixteenth of the block |
| block_ready | output | 1 | A full block arrived and reading has not started |

## Verification
The strobe passes through a two-flop synchroniser and then the handshake register, so the acknowledge and the byte write are due on the third rising edge after the strobe changes. The bench drives inputs on the falling edge and samples there. It checks that `port_ack` is still low after the second edge and high after the third. `block_ready` and `word_valid` are due in the same cycle as the 64th write, so they are sampled right after that acknowledge. On the read side, words and flags change only at an edge where ready is high. The bench therefore compares `word_data` one half-cycle before each edge and again after stalled edges.

// File: rtl/byte_pack_pkg.sv
package byte_pack_pkg;
  typedef enum logic [0:0] {
    HS_IDLE = 1'b0,
    HS_HELD = 1'b1
  } hs_state_t;
endpackage

// File: rtl/pk_sync.sv
module pk_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d_async[b]};
    end
    assign q_sync[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/pk_port_fsm.sv
module pk_port_fsm
  import byte_pack_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe_s,
  input  logic             load_en,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic             block_filled,
  output logic             ack
);
  hs_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    wr_en   = 1'b0;
    unique case (state_q)
      HS_IDLE: if (strobe_s && load_en) begin
        wr_en   = 1'b1;
        state_d = HS_HELD;
      end
      HS_HELD: if (!strobe_s) state_d = HS_IDLE;
      default: state_d = HS_IDLE;
    endcase
  end

  assign block_filled = wr_en && (wr_idx == IDX_W'(DEPTH - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HS_IDLE;
      wr_idx  <= '0;
    end else begin
      state_q <= state_d;
      if (wr_en) wr_idx <= block_filled ? '0 : wr_idx + 1'b1;
    end
  end

  assign ack = (state_q == HS_HELD);
endmodule

// File: rtl/pk_byte_buf.sv
module pk_byte_buf #(
  parameter int DEPTH      = 64,
  parameter int WORD_BYTES = 4,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int WORDS  = DEPTH / WORD_BYTES,
  localparam int WIDX_W = $clog2(WORDS)
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [7:0]              wr_byte,
  input  logic [WIDX_W-1:0]       rd_word,
  output logic [WORD_BYTES*8-1:0] rd_data
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_byte;
  end

  for (genvar l = 0; l < WORD_BYTES; l++) begin : g_lane
    localparam int HI = (WORD_BYTES - l) * 8 - 1;
    logic [IDX_W-1:0] addr;
    assign addr = {rd_word, {($clog2(WORD_BYTES)){1'b0}}} + IDX_W'(l);
    assign rd_data[HI -: 8] = mem[addr];
  end
endmodule

// File: rtl/pk_read_seq.sv
module pk_read_seq #(
  parameter int WORDS = 16,
  localparam int WIDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              block_filled,
  input  logic              word_ready,
  output logic              holding,
  output logic              block_ready,
  output logic              word_last,
  output logic [WIDX_W-1:0] rd_word
);
  logic accept, last_word;

  assign accept    = holding && word_ready;
  assign last_word = (rd_word == WIDX_W'(WORDS - 1));
  assign word_last = holding && last_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holding     <= 1'b0;
      block_ready <= 1'b0;
      rd_word     <= '0;
    end else begin
      if (block_filled) begin
        holding     <= 1'b1;
        block_ready <= 1'b1;
      end else begin
        if (accept) block_ready <= 1'b0;
        if (accept && last_word) holding <= 1'b0;
      end
      if (accept) rd_word <= last_word ? '0 : rd_word + 1'b1;
    end
  end
endmodule

// File: rtl/byte_word_packer.sv
module byte_word_packer #(
  parameter int DEPTH      = 64,
  parameter int WORD_BYTES = 4,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int WORDS  = DEPTH / WORD_BYTES,
  localparam int WIDX_W = $clog2(WORDS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    hash_done,
  input  logic [7:0]              port_data,
  input  logic                    port_valid,
  output logic                    port_ack,
  output logic [WORD_BYTES*8-1:0] word_data,
  output logic                    word_valid,
  input  logic                    word_ready,
  output logic                    word_last,
  output logic                    block_ready
);
  logic              valid_s;
  logic              wr_en, block_filled, holding;
  logic [IDX_W-1:0]  wr_idx;
  logic [WIDX_W-1:0] rd_word;

  pk_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(port_valid), .q_sync(valid_s)
  );

  pk_port_fsm #(.DEPTH(DEPTH)) u_fsm (
    .clk(clk), .rst_n(rst_n), .strobe_s(valid_s),
    .load_en(hash_done && !holding),
    .wr_en(wr_en), .wr_idx(wr_idx), .block_filled(block_filled), .ack(port_ack)
  );

  pk_byte_buf #(.DEPTH(DEPTH), .WORD_BYTES(WORD_BYTES)) u_buf (
    .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_byte(port_data),
    .rd_word(rd_word), .rd_data(word_data)
  );

  pk_read_seq #(.WORDS(WORDS)) u_rd (
    .clk(clk), .rst_n(rst_n), .block_filled(block_filled), .word_ready(word_ready),
    .holding(holding), .block_ready(block_ready), .word_last(word_last),
    .rd_word(rd_word)
  );

  assign word_valid = holding;
endmodule

// File: rtl/pk_checker.sv
module pk_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         hash_done,
  input logic         valid_s,
  input logic         port_ack,
  input logic [W-1:0] word_data,
  input logic         word_valid,
  input logic         word_ready,
  input logic         word_last,
  input logic         block_ready
);
  assert_ack_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    port_ack && valid_s |=> port_ack);

  assert_no_ack_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !hash_done && !port_ack |=> !port_ack);

  assert_stall_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && !word_ready |=> word_valid && $stable(word_data));

  assert_last_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    word_last && word_ready |=> !word_valid);

  assert_last_needs_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    word_last |-> word_valid);

  assert_ready_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    block_ready && word_ready |=> !block_ready);

  assert_ready_implies_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    block_ready |-> word_valid);

  assert_no_ack_holding_R10: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && !port_ack |=> !port_ack);
endmodule

bind byte_word_packer pk_checker #(.W(WORD_BYTES*8)) u_chk (
  .clk(clk), .rst_n(rst_n), .hash_done(hash_done), .valid_s(valid_s),
  .port_ack(port_ack), .word_data(word_data), .word_valid(word_valid),
  .word_ready(word_ready), .word_last(word_last), .block_ready(block_ready)
);

// File: tb/sim_byte_word_packer.sv
module sim_byte_word_packer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hash_done = 1'b1;
  logic [7:0]  port_data = '0;
  logic        port_valid = 1'b0;
  logic        port_ack;
  logic [31:0] word_data;
  logic        word_valid, word_ready = 1'b0, word_last, block_ready;

  int tests = 0, fails = 0;
  logic [7:0] exp_mem [64];
  int         nbytes = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;

  byte_word_packer u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input int k);
    return {exp_mem[4*k], exp_mem[4*k+1], exp_mem[4*k+2], exp_mem[4*k+3]};
  endfunction

  // full transfer; returns when ack dropped
  task automatic send_byte(input logic [7:0] b, input int hold, input bit timed);
    int n = 0;
    @(negedge clk);
    port_data = b; port_valid = 1'b1;
    if (timed) begin
      @(negedge clk); @(negedge clk);
      chk(port_ack == 1'b0, "R2 ack early", 32'(port_ack), 0);
      @(negedge clk);
      chk(port_ack == 1'b1, "R2 ack at 3rd edge", 32'(port_ack), 1);
    end else begin
      while (!port_ack && n < 2000) begin @(negedge clk); n++; end
    end
    exp_mem[nbytes] = b;
    nbytes++;
    chk(block_ready == (nbytes == 64), "R5 block_ready timing", 32'(block_ready), 32'(nbytes == 64));
    chk(word_valid == (nbytes == 64), "R5 word_valid timing", 32'(word_valid), 32'(nbytes == 64));
    if (nbytes == 64) nbytes = 0;
    repeat (hold) @(negedge clk);
    port_valid = 1'b0;
    if (timed) begin
      @(negedge clk); @(negedge clk);
      chk(port_ack == 1'b1, "R2 ack held", 32'(port_ack), 1);
      @(negedge clk);
      chk(port_ack == 1'b0, "R2 ack release", 32'(port_ack), 0);
    end else begin
      n = 0;
      while (port_ack && n < 2000) begin @(negedge clk); n++; end
    end
  endtask

  task automatic drain(input bit random_stall);
    for (int k = 0; k < 16; k++) begin
      while (random_stall && ($urandom % 3 == 0)) begin
        word_ready = 1'b0;
        @(negedge clk);
        chk(word_valid && word_data == exp_word(k), "R7 stall hold", word_data, exp_word(k));
      end
      chk(word_valid, "R8 valid during block", 32'(word_valid), 1);
      chk(word_data == exp_word(k), "R6 word order", word_data, exp_word(k));
      chk(word_last == (k == 15), "R8 word_last", 32'(word_last), 32'(k == 15));
      word_ready = 1'b1;
      @(negedge clk);
      word_ready = 1'b0;
      if (k == 0) chk(!block_ready, "R9 block_ready clear", 32'(block_ready), 0);
    end
    chk(!word_valid, "R8 valid drops after last", 32'(word_valid), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed = $urandom(32'd1234);
    int n;
    repeat (3) @(negedge clk);
    chk(!port_ack && !word_valid && !word_last && !block_ready, "R1 reset state",
        {port_ack, word_valid, word_last, block_ready}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // block 1: directed timing on first byte, long hold (R3), rest random
    send_byte(8'hA5, 0, 1);
    send_byte(8'h3C, 12, 1);                // R3: long strobe, one byte
    for (int i = 2; i < 64; i++) send_byte(8'($urandom), $urandom % 3, 0);
    drain(0);

    // block 2: gating by hash_done (R4) and random stalls
    hash_done = 1'b0;
    @(negedge clk);
    port_data = 8'h5E; port_valid = 1'b1;
    repeat (10) @(negedge clk);
    chk(!port_ack, "R4 gated no ack", 32'(port_ack), 0);
    hash_done = 1'b1;
    n = 0;
    while (!port_ack && n < 20) begin @(negedge clk); n++; end
    chk(port_ack, "R4 resumes", 32'(port_ack), 1);
    exp_mem[nbytes] = 8'h5E; nbytes++;
    port_valid = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 1; i < 64; i++) send_byte(8'($urandom), $urandom % 2, 0);

    // R10: strobe while block held is not acknowledged
    @(negedge clk);
    port_data = 8'hC7; port_valid = 1'b1;
    repeat (8) @(negedge clk);
    chk(!port_ack, "R10 held block blocks load", 32'(port_ack), 0);
    drain(1);
    n = 0;
    while (!port_ack && n < 20) begin @(negedge clk); n++; end
    chk(port_ack, "R10 load resumes", 32'(port_ack), 1);
    exp_mem[nbytes] = 8'hC7; nbytes++;
    port_valid = 1'b0;
    repeat (4) @(negedge clk);

    // block 3: edge pattern bytes
    for (int i = 1; i < 64; i++) send_byte((i % 2) ? 8'hFF : 8'h00, 0, 0);
    drain(1);

    repeat (5) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule